// File: doc/BRIEF.md
# Programmable-Tap Delay Line

This block delays a byte-wide data stream by a number of clock cycles chosen at run time, anywhere from one to sixteen. A 4-bit length code picks the latency. Incoming samples advance on every rising clock edge through a fixed chain of fifteen stage registers. A tap multiplexer then forwards either the live input or one chain stage into a dedicated output register, which drives the output bus.

The length code is first captured in a register of its own, and the multiplexer is steered from that registered copy. Because the code only chooses a tap, software or control logic can move it at any moment. The chain keeps shifting and its contents stay intact, so the samples already held in the chain are still valid after a change. A synchronous active-high reset clears the chain, the output register and the code register.

Top module: `tap_delay_line`

## Requirements
- R1: While `rst` is high at a rising edge, the chain stages, the output register and the registered code are all set to zero. In the first cycle after reset, `dout` follows the input with a one-cycle delay. Zeros then come out of the chain until new data reaches the selected tap.
- R2: With a steady length code n, where 1 <= n <= 14, `dout` equals the `din` value that was sampled n+1 rising edges earlier.
- R3: Code 0 is the shortest path. `din` goes straight into the output register, so `dout` equals `din` from the previous edge.
- R4: Code 15 is the longest path. It gives a delay of 16 cycles, with the output register taking its data from the fifteenth chain stage.
- R5: `len_code` is sampled on every rising edge. The value sampled at edge e steers the tap that the output register loads at edge e+1.
- R6: A change of `len_code` never alters the contents of the chain. After any change, the output shows the input history that the new tap points to.
- R7: All 8 data bits pass through the delay unchanged and without reordering.
- R8: The chain advances by one stage on every rising edge outside reset, whatever the code is. Stage 1 loads `din`, and stage k loads stage k-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Input sample |
| len_code | input | 4 | Length code; delay is code + 1 cycles |
| dout | output | 8 | Delayed sample from the output register |

## Verification
The bench steps through every code as a steady latency, including the shortest path (code 0) and the deepest tap (code 15). A design that miscounted a stage would give a delay that is off by one, and one that dropped the code register would switch taps a cycle too early. The bench also changes the code every few cycles and then on every cycle. A design that cleared or stalled the chain on a code change would put stale or zero samples on the output at that point. Reset is checked both for the zero output and for the zero-filled chain: a design that did not clear the chain would leak data from before reset while code 15 is active.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  // Number of chain stages reachable by a code of the given width.
  function automatic int tdl_stage_count(input int code_w);
    return (1 << code_w) - 1;
  endfunction

  // Latency in cycles produced by a length code.
  function automatic int tdl_latency(input int code);
    return code + 1;
  endfunction

endpackage

// File: rtl/tdl_shift_chain.sv
module tdl_shift_chain #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 15
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [WIDTH-1:0]               din,
  output logic [STAGES:0][WIDTH-1:0]     taps
);

  // taps[0] is the live input; taps[k] is chain stage k
  assign taps[0] = din;

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) taps[k] <= '0;
      else     taps[k] <= taps[k-1];
    end
  end

endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux #(
  parameter int WIDTH  = 8,
  parameter int CODE_W = 4,
  parameter int STAGES = (1 << CODE_W) - 1
) (
  input  logic [STAGES:0][WIDTH-1:0] taps,
  input  logic [CODE_W-1:0]          sel,
  output logic [WIDTH-1:0]           picked
);

  always_comb begin
    picked = '0;
    for (int k = 0; k <= STAGES; k++) begin
      if (sel == CODE_W'(k)) picked = taps[k];
    end
  end

endmodule

// File: rtl/tap_delay_line.sv
module tap_delay_line #(
  parameter int WIDTH  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  din,
  input  logic [CODE_W-1:0] len_code,
  output logic [WIDTH-1:0]  dout
);
  import tdl_pkg::*;

  localparam int STAGES = tdl_stage_count(CODE_W);

  logic [CODE_W-1:0]          len_q;
  logic [STAGES:0][WIDTH-1:0] taps;
  logic [WIDTH-1:0]           tap_data;

  // registered length code
  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else     len_q <= len_code;
  end

  tdl_shift_chain #(
    .WIDTH  (WIDTH),
    .STAGES (STAGES)
  ) i_chain (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .taps (taps)
  );

  tdl_tap_mux #(
    .WIDTH  (WIDTH),
    .CODE_W (CODE_W),
    .STAGES (STAGES)
  ) i_mux (
    .taps   (taps),
    .sel    (len_q),
    .picked (tap_data)
  );

  // output register
  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= tap_data;
  end

endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
  parameter int WIDTH  = 8,
  parameter int CODE_W = 4,
  parameter int STAGES = (1 << CODE_W) - 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [WIDTH-1:0]           din,
  input logic [CODE_W-1:0]          len_code,
  input logic [WIDTH-1:0]           dout,
  input logic [CODE_W-1:0]          len_q,
  input logic [STAGES:0][WIDTH-1:0] taps
);

  // R1: reset clears the output register and the code register
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (dout == '0 && len_q == '0));

  // R5: code sampled at one edge appears in the code register
  p_code_capture_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> len_q == $past(len_code));

  // R3: code 0 forwards the input to the output in one cycle
  p_short_path_r3: assert property (@(posedge clk) disable iff (rst)
    (len_q == '0) |=> dout == $past(din));

  // R4: code 15 takes the last chain stage
  p_long_path_r4: assert property (@(posedge clk) disable iff (rst)
    (len_q == CODE_W'(STAGES)) |=> dout == $past(taps[STAGES]));

  // R8: first stage loads the input on every edge
  p_first_stage_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> taps[1] == $past(din));

  // R6: stages keep shifting whatever the code does
  for (genvar k = 2; k <= STAGES; k++) begin : g_shift_chk
    p_chain_intact_r6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> taps[k] == $past(taps[k-1]));
  end

endmodule

bind tap_delay_line tdl_checker #(
  .WIDTH  (WIDTH),
  .CODE_W (CODE_W)
) i_tdl_checker (
  .clk      (clk),
  .rst      (rst),
  .din      (din),
  .len_code (len_code),
  .dout     (dout),
  .len_q    (len_q),
  .taps     (taps)
);

// File: tb/test_tap_delay_line.sv
`timescale 1ns/1ps
module test_tap_delay_line;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic [3:0] len_code = '0;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tap_delay_line i_tap_delay_line (
    .clk(clk), .rst(rst), .din(din), .len_code(len_code), .dout(dout)
  );

  // Reference: record of past inputs and the code seen one edge ago
  logic [7:0] past_in [0:31];
  int         wr_ptr = 0;
  int         prev_code = 0;
  logic [7:0] exp_out = '0;

  function automatic int lag_for(input int code);
    return code + 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) past_in[i] = '0;
      wr_ptr = 0; prev_code = 0; exp_out = '0;
    end else begin
      past_in[wr_ptr] = din;
      // input taken lag_for(prev_code)-1 edges before this one
      exp_out = past_in[(wr_ptr - (lag_for(prev_code) - 1) + 32) % 32];
      wr_ptr = (wr_ptr + 1) % 32;
      prev_code = int'(len_code);
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s dout actual %02h expected %02h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step_check(input string req, input logic [7:0] d, input logic [3:0] c);
    @(negedge clk);
    check(req, dout, exp_out);
    din = d;
    len_code = c;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: during reset the output stays zero
    din = 8'hA5; len_code = 4'd15;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", dout, 8'h00);
    end
    rst = 1'b0;
    // R1: after reset code 15 exposes a zero-filled chain
    for (int i = 0; i < 20; i++) step_check("R1", 8'(i + 1), 4'd15);
    // R7: every-bit patterns through a mid-length tap
    step_check("R7", 8'hFF, 4'd5);
    step_check("R7", 8'h01, 4'd5);
    step_check("R7", 8'h80, 4'd5);
    step_check("R7", 8'h5A, 4'd5);
    for (int i = 0; i < 12; i++) step_check("R7", 8'($urandom), 4'd5);
    // R2 R3 R4: each code held steady
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < 40; i++) begin
        if (c == 0)       step_check("R3", 8'($urandom), 4'(c));
        else if (c == 15) step_check("R4", 8'($urandom), 4'(c));
        else              step_check("R2", 8'($urandom), 4'(c));
      end
    end
    // R5: code moves every few cycles, including extremes
    for (int i = 0; i < 300; i++) begin
      logic [3:0] nc;
      nc = (i % 5 == 0) ? 4'($urandom) : len_code;
      step_check("R5", 8'($urandom), nc);
    end
    step_check("R5", 8'h11, 4'd0);
    step_check("R5", 8'h22, 4'd15);
    step_check("R5", 8'h33, 4'd0);
    step_check("R5", 8'h44, 4'd15);
    // R6: code bounces to a short tap and back, chain must hold history
    for (int i = 0; i < 20; i++) step_check("R6", 8'(8'h60 + i), 4'd12);
    step_check("R6", 8'h90, 4'd1);
    step_check("R6", 8'h91, 4'd1);
    for (int i = 0; i < 20; i++) step_check("R6", 8'(8'hC0 + i), 4'd12);
    // R8: code changes on every cycle
    for (int i = 0; i < 400; i++) step_check("R8", 8'($urandom), 4'($urandom));
    for (int i = 0; i < 17; i++) step_check("R8", 8'($urandom), len_code);
    // R1: reset mid-stream, then long tap again
    @(negedge clk); rst = 1'b1; din = 8'h77; len_code = 4'd15;
    @(negedge clk); check("R1", dout, 8'h00);
    @(negedge clk); check("R1", dout, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < 18; i++) step_check("R1", 8'(8'hE0 + i), 4'd15);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule